// File: doc/BRIEF.md
# Skewed Four-Bank Pixel Scratchpad with Lane Crossbar

This block is a 16-bit scratchpad that feeds four parallel arithmetic lanes. It is split into four banks. Every request moves one word per lane, and all four lanes are served in a single cycle. A request picks one of two access shapes. In pixel mode, the four lanes see the red, green, blue and alpha components of one pixel. In component mode, the four lanes see one chosen component of four neighbouring pixels.

The block places each element in a bank chosen by the sum of its pixel index and its component index, modulo four. Because of this skew, both access shapes touch every bank exactly once, so no request has to wait on a bank conflict. A rotating crossbar sends lane data into the banks on writes. On reads it rotates the bank outputs back into lane order. A per-lane mask lets the arithmetic lanes write any subset of the four words. Reads come back through a register stage one clock after the request. The returned word stays on the output until the next read.

Top module: `scratch_xbar`

## Requirements
- R1: While reset is held, and directly after it is released, `rdValid` is 0 and `rdData` is all zero.
- R2: A pixel-mode read (`reqMode`=0) of pixel p returns component i of pixel p on lane i. Lane i occupies bits [16i+15:16i]. Components are numbered 0 red, 1 green, 2 blue, 3 alpha.
- R3: A component-mode read (`reqMode`=1) with pixel base p, where p is a multiple of 4, and component c returns component c of pixel p+i on lane i.
- R4: In component mode the two low bits of `reqPixel` are ignored, so the base used is `reqPixel` with bits [1:0] cleared.
- R5: A write uses the same lane-to-element mapping as a read in the same mode. Data written in either mode reads back correctly in either mode.
- R6: During a write, lane i changes its element only when `wrMask[i]` is 1. Elements of unmasked lanes keep their old values.
- R7: `rdValid` is 1 in exactly the cycle after a read request is accepted on a rising edge. It is 0 after writes and after idle cycles.
- R8: `rdData` keeps the result of the most recent read through idle cycles and write cycles.
- R9: Every read, in either mode, enables all four banks at once. A read in every cycle therefore returns a correct result in every following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present this cycle |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqMode | input | 1 | 0 = one pixel, four components; 1 = one component, four pixels |
| reqPixel | input | 8 | Pixel index (component mode: group base, low bits ignored) |
| reqComp | input | 2 | Component index used in component mode |
| wrMask | input | 4 | Per-lane write enable |
| wrData | input | 64 | Lane write data, lane i at bits [16i+15:16i] |
| rdValid | output | 1 | Read result present |
| rdData | output | 64 | Lane read data, lane i at bits [16i+15:16i] |

## Verification
Two things can share one cycle. The registered result of a read leaves the block in the same cycle that the next request enters it, and that next request may be a write to the same elements or a read in the other mode. The bench issues a request in every cycle, randomly mixing pixel reads, component reads, masked writes and idle cycles, so result delivery and new bank traffic overlap on most clocks. Each result is compared against a reference array that applies writes in request order. The returned word must reflect every earlier write and none of the later ones, and it must stay unchanged across the write and idle cycles that follow.

// File: rtl/scratch_xbar_pkg.sv
package scratch_xbar_pkg;

  // Four lanes and four banks are fixed by the pixel layout (four components).
  localparam int LANES      = 4;
  localparam int LANE_IDX_W = 2;

  // Strobes handed from the control to the datapath every cycle.
  typedef struct packed {
    logic [LANES-1:0]      bankRdEn;  // bank performs a read this cycle
    logic [LANES-1:0]      bankWrEn;  // bank performs a write this cycle
    logic [LANE_IDX_W-1:0] rot;       // crossbar rotation amount
    logic                  rdLoad;    // capture rotation for the read return
  } xb_strobe_t;

endpackage

// File: rtl/scratch_xbar_ctrl.sv
module scratch_xbar_ctrl
  import scratch_xbar_pkg::*;
#(
  parameter int ROW_W = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 reqValid,
  input  logic                 reqWrite,
  input  logic                 reqMode,
  input  logic [ROW_W-1:0]     reqPixel,
  input  logic [LANE_IDX_W-1:0] reqComp,
  input  logic [LANES-1:0]     wrMask,
  output xb_strobe_t           strobe,
  output logic [ROW_W-1:0]     bankRow [LANES],
  output logic                 rdValid
);

  logic                  isRead;
  logic                  isWrite;
  logic [LANE_IDX_W-1:0] rot;
  logic [ROW_W-1:0]      baseRow;

  assign isRead  = reqValid && !reqWrite;
  assign isWrite = reqValid && reqWrite;

  // Skew: element (p, c) lives in bank (p + c) mod 4.
  // Pixel mode: lane i holds component i, so bank b serves lane (b - p) mod 4.
  // Component mode: base is 4-aligned, lane i holds pixel base+i, so bank b
  // serves lane (b - c) mod 4.
  assign rot     = reqMode ? reqComp : reqPixel[LANE_IDX_W-1:0];
  assign baseRow = reqMode ? {reqPixel[ROW_W-1:LANE_IDX_W], {LANE_IDX_W{1'b0}}}
                           : reqPixel;

  for (genvar b = 0; b < LANES; b++) begin : g_bank
    localparam logic [LANE_IDX_W-1:0] BIDX = LANE_IDX_W'(b);
    logic [LANE_IDX_W-1:0] laneOfBank;

    assign laneOfBank = BIDX - rot;

    always_comb begin
      if (reqMode) begin
        bankRow[b] = baseRow | ROW_W'(laneOfBank);
      end else begin
        bankRow[b] = baseRow;
      end
    end

    assign strobe.bankRdEn[b] = isRead;
    assign strobe.bankWrEn[b] = isWrite && wrMask[laneOfBank];
  end

  assign strobe.rot    = rot;
  assign strobe.rdLoad = isRead;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdValid <= 1'b0;
    end else begin
      rdValid <= isRead;
    end
  end

endmodule

// File: rtl/scratch_xbar_datapath.sv
module scratch_xbar_datapath
  import scratch_xbar_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 256,
  parameter int ROW_W  = 8
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  xb_strobe_t              strobe,
  input  logic [ROW_W-1:0]        bankRow [LANES],
  input  logic [LANES*DATA_W-1:0] wrData,
  output logic [LANES*DATA_W-1:0] rdData
);

  logic [DATA_W-1:0]     wrLane [LANES];
  logic [DATA_W-1:0]     bankQ  [LANES];
  logic [LANE_IDX_W-1:0] rotQ;

  for (genvar i = 0; i < LANES; i++) begin : g_unpack
    assign wrLane[i] = wrData[i*DATA_W +: DATA_W];
  end

  for (genvar b = 0; b < LANES; b++) begin : g_bank
    localparam logic [LANE_IDX_W-1:0] BIDX = LANE_IDX_W'(b);
    logic [DATA_W-1:0]     mem [DEPTH];
    logic [LANE_IDX_W-1:0] srcLane;
    logic [DATA_W-1:0]     bankWdata;

    // Write crossbar: bank b takes the lane that maps onto it.
    assign srcLane   = BIDX - strobe.rot;
    assign bankWdata = wrLane[srcLane];

    always_ff @(posedge clk) begin
      if (strobe.bankWrEn[b]) begin
        mem[bankRow[b]] <= bankWdata;
      end
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        bankQ[b] <= '0;
      end else if (strobe.bankRdEn[b]) begin
        bankQ[b] <= mem[bankRow[b]];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rotQ <= '0;
    end else if (strobe.rdLoad) begin
      rotQ <= strobe.rot;
    end
  end

  // Read crossbar: lane i is fed by bank (i + rot) mod 4.
  for (genvar i = 0; i < LANES; i++) begin : g_rdLane
    localparam logic [LANE_IDX_W-1:0] LIDX = LANE_IDX_W'(i);
    logic [LANE_IDX_W-1:0] srcBank;
    assign srcBank = LIDX + rotQ;
    assign rdData[i*DATA_W +: DATA_W] = bankQ[srcBank];
  end

endmodule

// File: rtl/scratch_xbar.sv
module scratch_xbar
  import scratch_xbar_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int PIXELS = 256,
  localparam int ROW_W = $clog2(PIXELS),
  localparam int BUS_W = LANES * DATA_W
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  reqValid,
  input  logic                  reqWrite,
  input  logic                  reqMode,
  input  logic [ROW_W-1:0]      reqPixel,
  input  logic [LANE_IDX_W-1:0] reqComp,
  input  logic [LANES-1:0]      wrMask,
  input  logic [BUS_W-1:0]      wrData,
  output logic                  rdValid,
  output logic [BUS_W-1:0]      rdData
);

  xb_strobe_t       ctrlStrobe;
  logic [ROW_W-1:0] bankRow [LANES];

  scratch_xbar_ctrl #(
    .ROW_W(ROW_W)
  ) ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqWrite (reqWrite),
    .reqMode  (reqMode),
    .reqPixel (reqPixel),
    .reqComp  (reqComp),
    .wrMask   (wrMask),
    .strobe   (ctrlStrobe),
    .bankRow  (bankRow),
    .rdValid  (rdValid)
  );

  scratch_xbar_datapath #(
    .DATA_W (DATA_W),
    .DEPTH  (PIXELS),
    .ROW_W  (ROW_W)
  ) dp_i (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (ctrlStrobe),
    .bankRow (bankRow),
    .wrData  (wrData),
    .rdData  (rdData)
  );

endmodule

// File: rtl/scratch_xbar_chk.sv
module scratch_xbar_chk #(
  parameter int LANES = 4,
  parameter int BUS_W = 64
) (
  input logic             clk,
  input logic             rstN,
  input logic             reqValid,
  input logic             reqWrite,
  input logic [LANES-1:0] wrMask,
  input logic             rdValid,
  input logic [BUS_W-1:0] rdData,
  input logic [LANES-1:0] bankRdEn,
  input logic [LANES-1:0] bankWrEn
);

  assert_rd_latency_R7: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqWrite) |=> rdValid);

  assert_no_spurious_valid_R7: assert property (@(posedge clk) disable iff (!rstN)
    !(reqValid && !reqWrite) |=> !rdValid);

  assert_hold_result_R8: assert property (@(posedge clk) disable iff (!rstN)
    !(reqValid && !reqWrite) |=> $stable(rdData));

  assert_all_banks_R9: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqWrite) |-> (bankRdEn == {LANES{1'b1}} && bankWrEn == '0));

  assert_mask_count_R6: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqWrite) |-> ($countones(bankWrEn) == $countones(wrMask)));

  assert_no_stray_write_R6: assert property (@(posedge clk) disable iff (!rstN)
    !(reqValid && reqWrite) |-> (bankWrEn == '0));

endmodule

bind scratch_xbar scratch_xbar_chk #(
  .LANES (scratch_xbar_pkg::LANES),
  .BUS_W (BUS_W)
) chk_i (
  .clk      (clk),
  .rstN     (rstN),
  .reqValid (reqValid),
  .reqWrite (reqWrite),
  .wrMask   (wrMask),
  .rdValid  (rdValid),
  .rdData   (rdData),
  .bankRdEn (ctrlStrobe.bankRdEn),
  .bankWrEn (ctrlStrobe.bankWrEn)
);

// File: tb/scratch_xbar_tb.sv
`timescale 1ns/1ps
module scratch_xbar_tb_top;

  logic        clk = 1'b0;
  logic        rstN;
  logic        reqValid;
  logic        reqWrite;
  logic        reqMode;
  logic [7:0]  reqPixel;
  logic [1:0]  reqComp;
  logic [3:0]  wrMask;
  logic [63:0] wrData;
  logic        rdValid;
  logic [63:0] rdData;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic [15:0] model [256][4];
  bit          pendRead;
  logic [63:0] pendExp;
  string       pendTag;
  logic [63:0] lastRead;

  always #2 clk = ~clk;

  scratch_xbar dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqMode(reqMode), .reqPixel(reqPixel), .reqComp(reqComp),
    .wrMask(wrMask), .wrData(wrData), .rdValid(rdValid), .rdData(rdData)
  );

  function automatic logic [63:0] expRead(input logic m, input logic [7:0] p,
                                          input logic [1:0] c);
    logic [63:0] r;
    logic [7:0]  base;
    base = {p[7:2], 2'b00};
    for (int i = 0; i < 4; i++) begin
      if (m) r[i*16 +: 16] = model[base + 8'(i)][c];
      else   r[i*16 +: 16] = model[p][i];
    end
    return r;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic checkOutputs();
    if (pendRead) begin
      check(rdValid === 1'b1, "R7", 64'(rdValid), 64'd1);
      check(rdData === pendExp, pendTag, rdData, pendExp);
      lastRead = pendExp;
    end else begin
      check(rdValid === 1'b0, "R7", 64'(rdValid), 64'd0);
      check(rdData === lastRead, "R8", rdData, lastRead);
    end
  endtask

  // Called at a falling edge: judge the previous request, drive the next one.
  task automatic step(input logic v, input logic w, input logic m,
                      input logic [7:0] p, input logic [1:0] c,
                      input logic [3:0] mk, input logic [63:0] d,
                      input string tag);
    logic [7:0] base;
    checkOutputs();
    reqValid = v; reqWrite = w; reqMode = m; reqPixel = p;
    reqComp = c; wrMask = mk; wrData = d;
    pendRead = v && !w;
    if (pendRead) begin
      pendExp = expRead(m, p, c);
      pendTag = tag;
    end
    if (v && w) begin
      base = {p[7:2], 2'b00};
      for (int i = 0; i < 4; i++) begin
        if (mk[i]) begin
          if (m) model[base + 8'(i)][c] = d[i*16 +: 16];
          else   model[p][i] = d[i*16 +: 16];
        end
      end
    end
    @(negedge clk);
  endtask

  function automatic logic [63:0] rnd64();
    return {$urandom(), $urandom()};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rstN = 1'b0; reqValid = 0; reqWrite = 0; reqMode = 0;
    reqPixel = 0; reqComp = 0; wrMask = 0; wrData = 0;
    pendRead = 0; lastRead = '0; pendExp = '0; pendTag = "R2";
    repeat (3) @(negedge clk);
    check(rdValid === 1'b0, "R1", 64'(rdValid), 64'd0);
    check(rdData === 64'd0, "R1", rdData, 64'd0);
    rstN = 1'b1;
    @(negedge clk);
    check(rdValid === 1'b0, "R1", 64'(rdValid), 64'd0);
    check(rdData === 64'd0, "R1", rdData, 64'd0);

    // Fill the whole store with pixel-mode writes.
    for (int p = 0; p < 256; p++) step(1, 1, 0, 8'(p), 2'd0, 4'hF, rnd64(), "R5");

    // Directed cases.
    step(1, 0, 0, 8'd5,  2'd0, 4'h0, 64'd0, "R2");
    step(1, 0, 1, 8'd8,  2'd2, 4'h0, 64'd0, "R3");
    step(1, 0, 1, 8'd11, 2'd3, 4'h0, 64'd0, "R4");
    step(1, 0, 1, 8'd255, 2'd1, 4'h0, 64'd0, "R4");
    step(0, 0, 0, 8'd0,  2'd0, 4'h0, 64'd0, "R8");
    step(1, 1, 1, 8'd20, 2'd1, 4'b0101, rnd64(), "R6");
    for (int p = 20; p < 24; p++) step(1, 0, 0, 8'(p), 2'd0, 4'h0, 64'd0, "R6");
    step(1, 1, 0, 8'd30, 2'd0, 4'hF, rnd64(), "R5");
    for (int c = 0; c < 4; c++) step(1, 0, 1, 8'd28, 2'(c), 4'h0, 64'd0, "R5");
    step(1, 1, 1, 8'd40, 2'd2, 4'hF, rnd64(), "R5");
    step(1, 0, 0, 8'd42, 2'd0, 4'h0, 64'd0, "R5");

    // Back-to-back reads, modes alternating.
    for (int k = 0; k < 64; k++)
      step(1, 0, 1'(k & 1), 8'($urandom()), 2'($urandom()), 4'h0, 64'd0, "R9");

    // Random mix of all request kinds.
    for (int k = 0; k < 3000; k++) begin
      int op;
      logic [7:0] p;
      logic [1:0] c;
      op = int'($urandom() % 4);
      p  = 8'($urandom());
      c  = 2'($urandom());
      case (op)
        0: step(0, 0, 0, p, c, 4'h0, rnd64(), "R8");
        1: step(1, 1, 1'($urandom()), p, c, 4'($urandom()), rnd64(), "R5");
        2: step(1, 0, 0, p, c, 4'h0, 64'd0, "R2");
        default: step(1, 0, 1, p, c, 4'h0, 64'd0, (p[1:0] != 2'd0) ? "R4" : "R3");
      endcase
    end

    step(0, 0, 0, 8'd0, 2'd0, 4'h0, 64'd0, "R8");
    step(0, 0, 0, 8'd0, 2'd0, 4'h0, 64'd0, "R8");
    checkOutputs();

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule